// File: doc/BRIEF.md
# BCD Calendar Days-in-Month Decoder

This combinational helper turns a calendar date context into a day count. A year arrives as four packed BCD digits (thousands in the top nibble, ones in the bottom nibble). A leap indication is derived straight from those digits using digit-parity rules, so no binary conversion or division is needed. The year is tested for divisibility by 4, by 100 and by 400, and the three results are merged into one leap flag.

A 4-bit binary month (1 for January through 12 for December) is then decoded together with that flag. The result is a one-hot group of four lines that tells a display or date counter whether the month is 28, 29, 30 or 31 days long. Codes outside 1..12 drive every line low.

Top module: `cal_days_decoder`

## Requirements
- R1: Months 1, 3, 5, 7, 8, 10 and 12 raise only `days_oh[3]` (31 days).
- R2: Months 4, 6, 9 and 11 raise only `days_oh[2]` (30 days).
- R3: Month 2 raises only `days_oh[1]` (29 days) when the leap flag is 1, and only `days_oh[0]` (28 days) when it is 0.
- R4: Month codes 0, 13, 14 and 15 drive all four `days_oh` bits low.
- R5: At most one `days_oh` bit is high for any input, and exactly one for months 1..12.
- R6: A year whose last two digits form a multiple of 4 but not 00 is a leap year. The test uses the tens digit LSB and the ones digit bits 1:0: an even tens digit needs ones bits 1:0 = 00, and an odd tens digit needs 10.
- R7: A year ending in 00 whose first two digits are not a multiple of 4 is not a leap year.
- R8: A year ending in 00 whose first two digits form a multiple of 4 is a leap year.
- R9: A year that is not a multiple of 4 is not a leap year, and `leap` equals (div4 AND NOT div100) OR div400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| year_bcd | input | 16 | Year as four BCD digits; [15:12] thousands, [11:8] hundreds, [7:4] tens, [3:0] ones |
| month | input | 4 | Binary month code, 1 = January .. 12 = December |
| leap | output | 1 | High when the year is a leap year |
| days_oh | output | 4 | One-hot day count: bit 0 = 28, bit 1 = 29, bit 2 = 30, bit 3 = 31 |

## Verification
The bench builds the block with its default parameters: 4-bit BCD digits and a 4-bit month code. At these widths the full year range 0000 to 9999 can be swept exhaustively, so every century and every four-century boundary is checked against a modulo-arithmetic model. Each of the 16 month codes, including the four unused ones, is also driven with both a leap year and a common year, so the February split and the all-low output for unused codes are both covered.

// File: rtl/cal_pkg.sv
package cal_pkg;
  parameter int DIGIT_W  = 4;
  parameter int NDIGITS  = 4;
  parameter int MONTH_W  = 4;
  localparam int YEAR_W  = DIGIT_W * NDIGITS;
  localparam int NDAYS   = 4;

  localparam int D28 = 0;
  localparam int D29 = 1;
  localparam int D30 = 2;
  localparam int D31 = 3;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [NDAYS-1:0]   days_t;

  typedef struct packed {
    logic div4;
    logic zero;
  } pair_flags_t;
endpackage

// File: rtl/cal_pair_div4.sv
module cal_pair_div4
  import cal_pkg::*;
(
  input  digit_t      hi_digit,
  input  digit_t      lo_digit,
  output pair_flags_t flags
);
  logic even_hi;
  logic lo_00;
  logic lo_10;

  always_comb begin
    even_hi    = ~hi_digit[0];
    lo_00      = (lo_digit[1:0] == 2'b00);
    lo_10      = (lo_digit[1:0] == 2'b10);
    flags.div4 = (even_hi & lo_00) | (~even_hi & lo_10);
    flags.zero = (hi_digit == '0) && (lo_digit == '0);
  end

  always_comb begin
    if ((hi_digit <= 4'd9) && (lo_digit <= 4'd9)) begin
      AST_PAIR_DIV4: assert (flags.div4 == (((int'(hi_digit) * 10 + int'(lo_digit)) % 4) == 0)); // R6
    end
  end
endmodule

// File: rtl/cal_leap_flag.sv
module cal_leap_flag
  import cal_pkg::*;
(
  input  logic [YEAR_W-1:0] year_bcd,
  output logic              leap
);
  localparam int NPAIRS = NDIGITS / 2;

  pair_flags_t pair_f [NPAIRS];

  generate
    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
      cal_pair_div4 u_pair (
        .hi_digit (year_bcd[(2*p+2)*DIGIT_W-1 -: DIGIT_W]),
        .lo_digit (year_bcd[(2*p+1)*DIGIT_W-1 -: DIGIT_W]),
        .flags    (pair_f[p])
      );
    end
  endgenerate

  logic d4, d100, d400;

  always_comb begin
    d4   = pair_f[0].div4;
    d100 = pair_f[0].zero;
    d400 = pair_f[NPAIRS-1].div4 & d100;
    leap = (d4 & ~d100) | d400;
  end

  always_comb begin
    AST_D400_IMPLIES_D100: assert (!pair_f[NPAIRS-1].div4 || !pair_f[0].zero || leap); // R8
    AST_LEAP_NEEDS_D4: assert (!leap || pair_f[0].div4); // R9
    AST_CENTURY_RULE: assert (!(pair_f[0].zero && !pair_f[NPAIRS-1].div4) || !leap); // R7
  end
endmodule

// File: rtl/cal_month_days.sv
module cal_month_days
  import cal_pkg::*;
(
  input  logic [MONTH_W-1:0] month,
  input  logic               leap,
  output days_t              days_oh
);
  always_comb begin
    days_oh = '0;
    case (month)
      4'd1, 4'd3, 4'd5, 4'd7, 4'd8, 4'd10, 4'd12: days_oh[D31] = 1'b1;
      4'd4, 4'd6, 4'd9, 4'd11:                    days_oh[D30] = 1'b1;
      4'd2: begin
        if (leap) days_oh[D29] = 1'b1;
        else      days_oh[D28] = 1'b1;
      end
      default: days_oh = '0;
    endcase
  end

  always_comb begin
    AST_ONEHOT0_DAYS: assert ($onehot0(days_oh)); // R5
    if (month == '0 || month > 4'd12) begin
      AST_BAD_MONTH_LOW: assert (days_oh == '0); // R4
    end else begin
      AST_GOOD_MONTH_ONE: assert ($countones(days_oh) == 1); // R5
    end
    if (month == 4'd2) begin
      AST_FEB_SPLIT: assert (days_oh[D29] == leap && days_oh[D28] == !leap); // R3
    end
  end
endmodule

// File: rtl/cal_days_decoder.sv
module cal_days_decoder
  import cal_pkg::*;
(
  input  logic [YEAR_W-1:0]  year_bcd,
  input  logic [MONTH_W-1:0] month,
  output logic               leap,
  output logic [NDAYS-1:0]   days_oh
);
  logic leap_w;

  cal_leap_flag u_leap (
    .year_bcd (year_bcd),
    .leap     (leap_w)
  );

  cal_month_days u_month (
    .month   (month),
    .leap    (leap_w),
    .days_oh (days_oh)
  );

  assign leap = leap_w;
endmodule

// File: tb/test_cal_days_decoder.sv
module test_cal_days_decoder;
  logic        clk;
  logic        rst_n;
  logic [15:0] year_bcd;
  logic [3:0]  month;
  logic        leap;
  logic [3:0]  days_oh;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic        leap;
    logic [3:0]  days;
    int          year;
    int          mon;
    string       tag_leap;
    string       tag_days;
  } exp_t;

  exp_t sb[$];

  cal_days_decoder i_cal_days_decoder (
    .year_bcd (year_bcd),
    .month    (month),
    .leap     (leap),
    .days_oh  (days_oh)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic model_leap(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic logic [3:0] model_days(int m, logic lp);
    if (m == 2) return lp ? 4'b0010 : 4'b0001;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 4'b0100;
    if (m >= 1 && m <= 12) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic string leap_tag(int y);
    if (y % 400 == 0) return "R8";
    if (y % 100 == 0) return "R7";
    if (y % 4 == 0)   return "R6";
    return "R9";
  endfunction

  function automatic string days_tag(int m);
    if (m == 2) return "R3";
    if (m == 4 || m == 6 || m == 9 || m == 11) return "R2";
    if (m >= 1 && m <= 12) return "R1";
    return "R4";
  endfunction

  function automatic logic [15:0] to_bcd(int y);
    return {4'((y / 1000) % 10), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
  endfunction

  task automatic drive(int y, int m);
    exp_t e;
    @(posedge clk);
    #1;
    year_bcd = to_bcd(y);
    month    = 4'(m);
    e.leap     = model_leap(y);
    e.days     = model_days(m, e.leap);
    e.year     = y;
    e.mon      = m;
    e.tag_leap = leap_tag(y);
    e.tag_days = days_tag(m);
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (leap !== e.leap) begin
        bad++;
        $display("FAIL %s leap year=%0d actual=%b expected=%b", e.tag_leap, e.year, leap, e.leap);
      end
      total++;
      if (days_oh !== e.days) begin
        bad++;
        $display("FAIL %s days year=%0d month=%0d actual=%b expected=%b",
                 e.tag_days, e.year, e.mon, days_oh, e.days);
      end
      total++;
      if ($countones(days_oh) > 1) begin
        bad++;
        $display("FAIL R5 multiple lines month=%0d actual=%b expected=onehot0", e.mon, days_oh);
      end
    end
  end

  initial begin
    rst_n    = 0;
    year_bcd = '0;
    month    = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // baseline: year 0000 (R8 leap), month 0 (R4)
    drive(0, 0);
    // R1 R2 R3 R4 R5: every month code, leap and common years
    for (int m = 0; m < 16; m++) drive(2024, m);
    for (int m = 0; m < 16; m++) drive(2023, m);
    for (int m = 0; m < 16; m++) drive(1900, m);
    for (int m = 0; m < 16; m++) drive(2000, m);
    // R6 R7 R8 R9: exhaustive year sweep, month varied with the year
    for (int y = 0; y < 10000; y++) drive(y, y % 16);
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
  end

  initial begin
    wait (done || total < 0);
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && total == 0 && bad > 0) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!done) begin
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end
endmodule